// File: doc/BRIEF.md
# Indirect Bus Access Bridge

The bridge is a register slave that gives software a way to reach any address on a system bus without mapping it directly. Software first loads a target address and a data word. It then writes a mode word, and that write alone launches one single-beat transaction on a small master port. The mode word decides four things: the direction, the security attribute presented on the bus, the enabled byte lanes, and (for reads) whether the address is aligned.

A read deposits its returned word in the data register. Software can load a sentinel value there beforehand and poll until the value changes. Polling the busy bit works as well.

Each security attribute has an address window it may not reach. A request that falls in that window never appears on the bus and sets a sticky error bit. A blocked read also zeroes the data register. A separate control offset accepts one key value, and that value latches a read kill that holds until reset.

Top module: `ind_access_bridge`

## Requirements
- R1: Byte offsets on the register port: 0x0 is the target address, 0x4 is data, 0x8 is mode, 0xC is status (bit 0 busy, bit 1 sticky error, bit 2 read kill) and 0x10 is control, which reads as zero. After reset, every one of these reads as zero.
- R2: A mode write with busy clear raises m_valid in the next cycle. m_write then equals mode bit 0 (1 for write, 0 for read).
- R3: m_attr is 2 (non-secure) when mode bit 2 is set. Otherwise it is 1 (alternate secure) when mode bit 1 is set. Otherwise it is 0 (default secure). The value 3 never appears.
- R4: A write presents the address register unchanged, the data register value captured at launch, and m_strb equal to mode bits 6:3 (bit 3 is lane 0).
- R5: A read presents the address register with bits 3:0 cleared, unless mode bit 4 is set. In that case the address passes unaligned.
- R6: A read drives m_strb from mode bits 6:3. Inside the full-word window (default 0xE0020000–0xE002FFFF) it drives 4'hF instead. On the handshake, the data register takes m_rdata with disabled lanes zeroed.
- R7: Busy stays set, and the request fields hold stable, from launch until m_valid and m_ready are both high.
- R8: A mode write while busy changes neither the mode register nor the bus request.
- R9: The forbidden windows are 0x00300000–0x003FFFFF for attribute 0, 0x40000000–0xBFFFFFFF for attribute 1 and 0xE0000000–0xE00FFFFF for attribute 2. They are checked against the issued address. A hit issues no request and sets the error bit. A blocked read also writes zero to the data register.
- R10: Writing 0x420 to offset 0x10 sets the read kill, which stays set until reset. While it is set, reads are blocked as in R9 and writes proceed. Writing any other value leaves the read kill unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| m_valid | output | 1 | Master request valid |
| m_ready | input | 1 | Master request accepted |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Master address |
| m_wdata | output | 32 | Master write data |
| m_strb | output | 4 | Byte-lane enables |
| m_attr | output | 2 | Security attribute (0 default, 1 alternate, 2 non-secure) |
| m_rdata | input | 32 | Read data, valid during the handshake |

## Verification
The bench builds the bridge with its default windows and read-kill key. It sweeps all 128 values of mode bits 6:0 over five target addresses. Between them, those addresses hit each attribute's forbidden window, the full-word window, an unaligned offset and open space. Downstream latency is also varied from zero to three wait cycles, so that every combination of attribute priority, lane masking, alignment and blocking is reached with both immediate and delayed acceptance. Separate passes cover a mode write issued while busy and the read-kill key, both with a wrong value and with the correct one.

// File: rtl/ind_access_bridge.sv
module ind_access_bridge #(
  parameter logic [31:0] DS_LO   = 32'h0030_0000,
  parameter logic [31:0] DS_HI   = 32'h003F_FFFF,
  parameter logic [31:0] AS_LO   = 32'h4000_0000,
  parameter logic [31:0] AS_HI   = 32'hBFFF_FFFF,
  parameter logic [31:0] NS_LO   = 32'hE000_0000,
  parameter logic [31:0] NS_HI   = 32'hE00F_FFFF,
  parameter logic [31:0] FULL_LO = 32'hE002_0000,
  parameter logic [31:0] FULL_HI = 32'hE002_FFFF,
  parameter logic [31:0] RD_KEY  = 32'h0000_0420
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [4:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        m_valid,
  input  logic        m_ready,
  output logic        m_write,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_strb,
  output logic [1:0]  m_attr,
  input  logic [31:0] m_rdata
);
  localparam logic [4:0] OFF_ADDR = 5'h00;
  localparam logic [4:0] OFF_DATA = 5'h04;
  localparam logic [4:0] OFF_MODE = 5'h08;
  localparam logic [4:0] OFF_STAT = 5'h0C;
  localparam logic [4:0] OFF_CTRL = 5'h10;

  logic [31:0] addr_q, data_q, mode_q;
  logic        busy, err, rd_off;

  logic        n_write, n_block, n_full, n_fb;
  logic [1:0]  n_attr;
  logic [31:0] n_addr;
  logic [3:0]  n_strb;
  logic        mode_wr;
  logic [31:0] lane_mask;

  assign mode_wr = cfg_wr && cfg_addr == OFF_MODE && !busy;
  assign n_write = cfg_wdata[0];
  assign n_attr  = cfg_wdata[2] ? 2'd2 : (cfg_wdata[1] ? 2'd1 : 2'd0);
  assign n_addr  = (n_write || cfg_wdata[4]) ? addr_q : {addr_q[31:4], 4'h0};
  assign n_full  = !n_write && n_addr >= FULL_LO && n_addr <= FULL_HI;
  assign n_strb  = n_full ? 4'hF : cfg_wdata[6:3];

  always_comb begin
    unique case (n_attr)
      2'd1:    n_fb = n_addr >= AS_LO && n_addr <= AS_HI;
      2'd2:    n_fb = n_addr >= NS_LO && n_addr <= NS_HI;
      default: n_fb = n_addr >= DS_LO && n_addr <= DS_HI;
    endcase
  end

  assign n_block = n_fb || (!n_write && rd_off);

  assign lane_mask = {{8{m_strb[3]}}, {8{m_strb[2]}}, {8{m_strb[1]}}, {8{m_strb[0]}}};
  assign m_valid   = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      busy    <= 1'b0;
      err     <= 1'b0;
      rd_off  <= 1'b0;
      m_write <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
      m_strb  <= '0;
      m_attr  <= '0;
    end else begin
      if (cfg_wr && cfg_addr == OFF_ADDR) addr_q <= cfg_wdata;
      if (cfg_wr && cfg_addr == OFF_DATA) data_q <= cfg_wdata;
      if (cfg_wr && cfg_addr == OFF_CTRL && cfg_wdata == RD_KEY) rd_off <= 1'b1;
      if (mode_wr) begin
        mode_q <= cfg_wdata;
        if (n_block) begin
          err <= 1'b1;
          if (!n_write) data_q <= '0;
        end else begin
          busy    <= 1'b1;
          m_write <= n_write;
          m_addr  <= n_addr;
          m_wdata <= data_q;
          m_strb  <= n_strb;
          m_attr  <= n_attr;
        end
      end
      if (busy && m_ready) begin
        busy <= 1'b0;
        if (!m_write) data_q <= m_rdata & lane_mask;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      OFF_ADDR: cfg_rdata = addr_q;
      OFF_DATA: cfg_rdata = data_q;
      OFF_MODE: cfg_rdata = mode_q;
      OFF_STAT: cfg_rdata = {29'd0, rd_off, err, busy};
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ind_access_bridge_chk.sv
module ind_access_bridge_chk #(
  parameter logic [31:0] AS_LO = 32'h4000_0000,
  parameter logic [31:0] AS_HI = 32'hBFFF_FFFF,
  parameter logic [31:0] NS_LO = 32'hE000_0000,
  parameter logic [31:0] NS_HI = 32'hE00F_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [4:0]  cfg_addr,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_write,
  input logic [31:0] m_addr,
  input logic [31:0] m_wdata,
  input logic [3:0]  m_strb,
  input logic [1:0]  m_attr,
  input logic [31:0] mode_q,
  input logic        rd_off
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_wdata)
      && $stable(m_strb) && $stable(m_attr) && $stable(m_write));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && cfg_wr && cfg_addr == 5'h08 |=> $stable(mode_q));

  p_attr_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_attr != 2'd3);

  p_as_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_attr == 2'd1 |-> !(m_addr >= AS_LO && m_addr <= AS_HI));

  p_ns_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_attr == 2'd2 |-> !(m_addr >= NS_LO && m_addr <= NS_HI));

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_write && m_addr[3:0] != 4'h0 |-> m_strb[1]);

  p_kill_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_off |=> rd_off);

  p_kill_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_off && $rose(m_valid) |-> m_write);
endmodule

bind ind_access_bridge ind_access_bridge_chk #(
  .AS_LO(AS_LO), .AS_HI(AS_HI), .NS_LO(NS_LO), .NS_HI(NS_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
  .m_wdata(m_wdata), .m_strb(m_strb), .m_attr(m_attr),
  .mode_q(mode_q), .rd_off(rd_off)
);

// File: tb/sim_ind_access_bridge.sv
module sim_ind_access_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        m_valid, m_ready, m_write;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_strb;
  logic [1:0]  m_attr;

  int checks = 0;
  int fails = 0;
  logic [2:0]  lat = 3'd0;
  logic [3:0]  wcnt;
  int          n_req;
  logic [31:0] c_addr, c_wdata;
  logic [3:0]  c_strb;
  logic [1:0]  c_attr;
  logic        c_write;
  logic        exp_err = 1'b0;
  logic        exp_kill = 1'b0;

  always #2 clk = ~clk;

  ind_access_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_valid(m_valid),
    .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_strb(m_strb), .m_attr(m_attr), .m_rdata(m_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  assign m_rdata = mem_word(m_addr);
  assign m_ready = m_valid && (wcnt == {1'b0, lat});

  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      n_req <= 0;
    end else if (m_valid && m_ready) begin
      wcnt    <= '0;
      n_req   <= n_req + 1;
      c_addr  <= m_addr;
      c_wdata <= m_wdata;
      c_strb  <= m_strb;
      c_attr  <= m_attr;
      c_write <= m_write;
    end else if (m_valid) begin
      wcnt <= wcnt + 4'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] o, input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = o; cfg_wdata = v;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [4:0] o, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = o;
    #1 v = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 40; i++) begin
      cfg_read(5'h0C, s);
      if (!s[0]) break;
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [31:0] d, input logic [6:0] m);
    logic [31:0] eff, rd, mask;
    logic [1:0]  attr;
    logic [3:0]  strb;
    logic        wr, fb, blk;
    int          n0;
    wr   = m[0];
    attr = m[2] ? 2'd2 : (m[1] ? 2'd1 : 2'd0);
    eff  = (wr || m[4]) ? a : (a & 32'hFFFF_FFF0);
    case (attr)
      2'd1:    fb = eff >= 32'h4000_0000 && eff <= 32'hBFFF_FFFF;
      2'd2:    fb = eff >= 32'hE000_0000 && eff <= 32'hE00F_FFFF;
      default: fb = eff >= 32'h0030_0000 && eff <= 32'h003F_FFFF;
    endcase
    blk  = fb || (!wr && exp_kill);
    strb = (!wr && eff >= 32'hE002_0000 && eff <= 32'hE002_FFFF) ? 4'hF : m[6:3];
    mask = {{8{strb[3]}}, {8{strb[2]}}, {8{strb[1]}}, {8{strb[0]}}};
    if (blk) exp_err = 1'b1;
    lat = 3'(m % 4);
    cfg_write(5'h00, a);
    cfg_write(5'h04, d);
    n0 = n_req;
    cfg_write(5'h08, {25'd0, m});
    wait_idle();
    cfg_read(5'h08, rd);
    chk("R1 mode readback", rd, {25'd0, m});
    cfg_read(5'h0C, rd);
    chk("R1/R9 status", rd, {29'd0, exp_kill, exp_err, 1'b0});
    if (blk) begin
      chk("R9 no request", 32'(n_req - n0), 32'd0);
      cfg_read(5'h04, rd);
      chk("R9 blocked data", rd, wr ? d : 32'd0);
    end else begin
      chk("R2 one request", 32'(n_req - n0), 32'd1);
      chk("R2 direction", {31'd0, c_write}, {31'd0, wr});
      chk("R3 attribute", {30'd0, c_attr}, {30'd0, attr});
      chk("R4/R5 address", c_addr, eff);
      chk("R4/R6 strobe", {28'd0, c_strb}, {28'd0, strb});
      if (wr) chk("R4 wdata", c_wdata, d);
      cfg_read(5'h04, rd);
      chk("R6 data reg", rd, wr ? d : (mem_word(eff) & mask));
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] addrs [5];
    int n0;
    addrs[0] = 32'h0000_1234; addrs[1] = 32'h0030_0008; addrs[2] = 32'h5000_0004;
    addrs[3] = 32'hE002_0047; addrs[4] = 32'hE008_0019;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int o = 0; o <= 16; o += 4) begin
      cfg_read(5'(o), v);
      chk("R1 reset value", v, 32'd0);
    end
    cfg_write(5'h00, 32'hCAFE_0001);
    cfg_read(5'h00, v);
    chk("R1 address readback", v, 32'hCAFE_0001);

    for (int ai = 0; ai < 5; ai++)
      for (int m = 0; m < 128; m++)
        access(addrs[ai], 32'h1357_0000 + 32'(m), 7'(m));

    lat = 3'd6;
    cfg_write(5'h00, 32'h0000_2000);
    n0 = n_req;
    cfg_write(5'h08, 32'h78);
    cfg_write(5'h08, 32'h01);
    cfg_read(5'h0C, v);
    chk("R7 busy during wait", {31'd0, v[0]}, 32'd1);
    cfg_read(5'h08, v);
    chk("R8 mode unchanged", v, 32'h78);
    wait_idle();
    chk("R8 single request", 32'(n_req - n0), 32'd1);
    chk("R8 direction kept", {31'd0, c_write}, 32'd0);
    cfg_read(5'h04, v);
    chk("R7 read result", v, mem_word(32'h0000_2000));

    cfg_write(5'h10, 32'h421);
    cfg_read(5'h0C, v);
    chk("R10 wrong key", {31'd0, v[2]}, 32'd0);
    access(32'h0000_1234, 32'h0, 7'h78);
    cfg_write(5'h10, 32'h420);
    exp_kill = 1'b1;
    cfg_read(5'h10, v);
    chk("R1 control reads zero", v, 32'd0);
    access(32'h0000_1234, 32'hFFFF_FFFF, 7'h78);
    access(32'h0000_1238, 32'h2468_ACE0, 7'h79);
    access(32'hE002_0040, 32'h1, 7'h08);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule